// File: doc/BRIEF.md
# Frame-Synchronised Wait and Step-Pulse Generator

This block paces a two-channel stepper drive from a video-frame sync signal. A rising edge on `sync` starts two waits, one after the other. The first wait lasts N units and the second lasts M units. One unit is 2^UNIT_LOG2 clocks, which is 1024 by default. When both waits are over, each channel emits a burst of single-clock step pulses. The number of pulses is four times the channel's count byte, and the pulses are a programmed number of clocks apart. Serial reception, checksum calculation and current control are outside this block. They present their results to it as plain, already-latched inputs.

The block samples its inputs at fixed moments of the frame:

- The wait codes are taken at the sync edge.
- The per-channel count, period and checksum flag are taken when the combined wait ends.
- A rise of the channel enable takes effect when the first wait ends. A fall of the enable takes effect when the combined wait ends.

A zero in either wait code marks the frame's parameters as invalid. The block then keeps the previous valid wait codes and the previous valid channel parameters. A new sync edge always restarts the waits and cuts off any burst in progress. A wait set longer than the sync period therefore never reaches a burst.

Top module: `frame_step_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, every output is low.
- R2: After a sampled `sync` rise, `wait1_flag` is high for exactly N×2^UNIT_LOG2 cycles. These cycles start in the cycle after the edge, and N is the 8-bit `wait1_code`.
- R3: `wait2_flag` rises together with `wait1_flag` and stays high for (N+M)×2^UNIT_LOG2 cycles. M is `wait2_code`. `wait1_flag` is never high while `wait2_flag` is low.
- R4: If either wait code is 0 at the sync edge, the frame uses the last valid wait codes. It also uses the last valid count, period and checksum flag of each channel.
- R5: A burst on a channel with count byte C and period P has 4×C pulses. The first pulse comes P cycles after `wait2_flag` falls. Each pulse is one cycle wide, and consecutive pulses are P cycles apart. With P=1 the pulses are back to back.
- R6: `gate[i]` rises in the cycle `wait2_flag` falls and stays high for 4×C×P+1 cycles. It falls in the cycle after the last pulse.
- R7: A channel produces no gate and no pulse in a frame whose count byte is 0, whose period is 0, or whose `csum_ok` bit is low.
- R8: A `sync` rise clears any burst in progress in the next cycle and restarts the waits. If the sync period is shorter than the combined wait, no burst is ever issued.
- R9: While a channel's enable is off, its gate still runs and its pulses are still counted, but `step[i]` stays low. A rising enable is applied when the first wait ends. A falling enable is applied when the combined wait ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Frame sync, rising edge starts a frame |
| wait1_code | input | 8 | First wait length in units (0 = invalid) |
| wait2_code | input | 8 | Magnetize wait length in units (0 = invalid) |
| pcount | input | 8×NCH | Per-channel count byte, channel i at bits [8i+7:8i] |
| period | input | 16×NCH | Per-channel pulse period in clocks, channel i at bits [16i+15:16i] |
| chan_en | input | NCH | Per-channel output enable |
| csum_ok | input | NCH | Per-channel parameter checksum good |
| wait1_flag | output | 1 | High during the first wait |
| wait2_flag | output | 1 | High during both waits |
| gate | output | NCH | Per-channel burst in progress |
| step | output | NCH | Per-channel step pulse |

## Verification
On every cycle, the assertions check the following:

- the first-wait flag lies inside the combined-wait flag;
- the combined flag still holds when the first wait ends;
- a raw pulse only appears inside its gate;
- a gate only opens at the end of a combined wait;
- two adjacent pulses occur only with a period of one.

The bench scenarios show what no single-cycle rule can:

- the exact lengths of the waits and gates;
- the pulse counts and the position of the first pulse;
- reuse of old parameters after a zero wait code;
- the inhibit conditions and the enable masking;
- burst abort by a new sync, and starvation when the sync period is too short.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int CODE_W = 8;
  localparam int CNT_W  = 8;
  localparam int PER_W  = 16;
endpackage

// File: rtl/frame_wait_timer.sv
module frame_wait_timer
  import fsg_pkg::*;
#(
  parameter int UNIT_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic [CODE_W-1:0] wait1_code,
  input  logic [CODE_W-1:0] wait2_code,
  output logic              sync_rise,
  output logic              w1_end,
  output logic              w2_end,
  output logic              upd_ok,
  output logic              w1_flag,
  output logic              w2_flag
);
  localparam int TW = CODE_W + UNIT_LOG2;

  logic              sync_d;
  logic              codes_ok;
  logic              upd_q;
  logic              tmr_zero;
  logic [CODE_W-1:0] n_q;
  logic [CODE_W-1:0] m_q;
  logic [CODE_W-1:0] n_use;
  logic [TW-1:0]     n_len;
  logic [TW-1:0]     m_len;
  logic [TW-1:0]     tmr;

  assign sync_rise = sync & ~sync_d;
  assign codes_ok  = (wait1_code != '0) && (wait2_code != '0);
  assign n_use     = codes_ok ? wait1_code : n_q;
  assign n_len     = {n_use, {UNIT_LOG2{1'b0}}};
  assign m_len     = {m_q, {UNIT_LOG2{1'b0}}};
  assign tmr_zero  = (tmr == '0);
  assign w1_end    = w1_flag & tmr_zero & ~sync_rise;
  assign w2_end    = w2_flag & ~w1_flag & tmr_zero & ~sync_rise;
  assign upd_ok    = upd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_d  <= 1'b0;
      upd_q   <= 1'b0;
      n_q     <= '0;
      m_q     <= '0;
      tmr     <= '0;
      w1_flag <= 1'b0;
      w2_flag <= 1'b0;
    end else begin
      sync_d <= sync;
      if (sync_rise) begin
        upd_q <= codes_ok;
        if (codes_ok) begin
          n_q <= wait1_code;
          m_q <= wait2_code;
        end
        if (n_use != '0) begin
          w1_flag <= 1'b1;
          w2_flag <= 1'b1;
          tmr     <= n_len - TW'(1);
        end else begin
          w1_flag <= 1'b0;
          w2_flag <= 1'b0;
        end
      end else if (w1_flag) begin
        if (tmr_zero) begin
          w1_flag <= 1'b0;
          tmr     <= m_len - TW'(1);
        end else begin
          tmr <= tmr - TW'(1);
        end
      end else if (w2_flag) begin
        if (tmr_zero) w2_flag <= 1'b0;
        else          tmr <= tmr - TW'(1);
      end
    end
  end

  // R3: the first wait always lies inside the combined wait
  assert_nest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    w1_flag |-> w2_flag);

  // R2: the end of the first wait hands over to the magnetize wait
  assert_handover_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(w1_flag) |-> w2_flag);
endmodule

// File: rtl/burst_channel.sv
module burst_channel
  import fsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             w1_end,
  input  logic             w2_end,
  input  logic             upd_ok,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [PER_W-1:0] per_in,
  input  logic             ok_in,
  input  logic             en_in,
  output logic             gate,
  output logic             step
);
  localparam int REM_W = CNT_W + 2;

  logic [CNT_W-1:0] cnt_s;
  logic [CNT_W-1:0] cnt_use;
  logic [PER_W-1:0] per_s;
  logic [PER_W-1:0] per_use;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] pc;
  logic [REM_W-1:0] rem;
  logic             ok_s;
  logic             ok_use;
  logic             step_q;
  logic             en_q;

  assign cnt_use = upd_ok ? cnt_in : cnt_s;
  assign per_use = upd_ok ? per_in : per_s;
  assign ok_use  = upd_ok ? ok_in  : ok_s;
  assign step    = step_q & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_s  <= '0;
      per_s  <= '0;
      ok_s   <= 1'b0;
      per_q  <= '0;
      pc     <= '0;
      rem    <= '0;
      gate   <= 1'b0;
      step_q <= 1'b0;
    end else if (abort) begin
      gate   <= 1'b0;
      step_q <= 1'b0;
      rem    <= '0;
    end else if (w2_end) begin
      cnt_s  <= cnt_use;
      per_s  <= per_use;
      ok_s   <= ok_use;
      per_q  <= per_use;
      pc     <= per_use - PER_W'(1);
      rem    <= {cnt_use, 2'b00};
      gate   <= (cnt_use != '0) && (per_use != '0) && ok_use;
      step_q <= 1'b0;
    end else if (gate) begin
      if (rem == '0) begin
        gate   <= 1'b0;
        step_q <= 1'b0;
      end else if (pc == '0) begin
        step_q <= 1'b1;
        rem    <= rem - REM_W'(1);
        pc     <= per_q - PER_W'(1);
      end else begin
        step_q <= 1'b0;
        pc     <= pc - PER_W'(1);
      end
    end else begin
      step_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (w1_end && en_in) begin
      en_q <= 1'b1;
    end else if (w2_end && !en_in) begin
      en_q <= 1'b0;
    end
  end

  // R5: raw pulses only occur inside the burst gate
  assert_step_in_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_q |-> gate);

  // R6: a gate opens only when the combined wait has just ended
  assert_gate_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> $past(w2_end));

  // R5: adjacent pulses are only legal for a period of one
  assert_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q && $past(step_q)) |-> (per_q == PER_W'(1)));
endmodule

// File: rtl/frame_step_sequencer.sv
module frame_step_sequencer
  import fsg_pkg::*;
#(
  parameter int UNIT_LOG2 = 10,
  parameter int NCH       = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync,
  input  logic [CODE_W-1:0]    wait1_code,
  input  logic [CODE_W-1:0]    wait2_code,
  input  logic [NCH*CNT_W-1:0] pcount,
  input  logic [NCH*PER_W-1:0] period,
  input  logic [NCH-1:0]       chan_en,
  input  logic [NCH-1:0]       csum_ok,
  output logic                 wait1_flag,
  output logic                 wait2_flag,
  output logic [NCH-1:0]       gate,
  output logic [NCH-1:0]       step
);
  logic sync_rise;
  logic w1_end;
  logic w2_end;
  logic upd_ok;

  frame_wait_timer #(.UNIT_LOG2(UNIT_LOG2)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync       (sync),
    .wait1_code (wait1_code),
    .wait2_code (wait2_code),
    .sync_rise  (sync_rise),
    .w1_end     (w1_end),
    .w2_end     (w2_end),
    .upd_ok     (upd_ok),
    .w1_flag    (wait1_flag),
    .w2_flag    (wait2_flag)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    burst_channel ch_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .abort  (sync_rise),
      .w1_end (w1_end),
      .w2_end (w2_end),
      .upd_ok (upd_ok),
      .cnt_in (pcount[i*CNT_W +: CNT_W]),
      .per_in (period[i*PER_W +: PER_W]),
      .ok_in  (csum_ok[i]),
      .en_in  (chan_en[i]),
      .gate   (gate[i]),
      .step   (step[i])
    );
  end
endmodule

// File: tb/frame_step_sequencer_tb_top.sv
`timescale 1ns/1ps
module frame_step_sequencer_tb_top;
  localparam int UL = 4;
  localparam int U  = 1 << UL;

  typedef struct packed {
    logic [7:0]  n;
    logic [7:0]  m;
    logic [7:0]  c0;
    logic [15:0] p0;
    logic [7:0]  c1;
    logic [15:0] p1;
    logic [1:0]  en;
    logic [1:0]  ok;
  } vec_t;

  localparam vec_t TBL [5] = '{
    '{8'd1, 8'd1, 8'd2, 16'd3, 8'd1, 16'd5, 2'b11, 2'b11},
    '{8'd2, 8'd1, 8'd1, 16'd1, 8'd3, 16'd2, 2'b01, 2'b11},
    '{8'd1, 8'd2, 8'd0, 16'd4, 8'd2, 16'd1, 2'b11, 2'b11},
    '{8'd1, 8'd1, 8'd2, 16'd2, 8'd2, 16'd2, 2'b11, 2'b10},
    '{8'd3, 8'd1, 8'd1, 16'd0, 8'd1, 16'd7, 2'b11, 2'b11}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic [7:0]  wait1_code = '0;
  logic [7:0]  wait2_code = '0;
  logic [15:0] pcount = '0;
  logic [31:0] period = '0;
  logic [1:0]  chan_en = '0;
  logic [1:0]  csum_ok = '0;
  logic        wait1_flag;
  logic        wait2_flag;
  logic [1:0]  gate;
  logic [1:0]  step;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  frame_step_sequencer #(.UNIT_LOG2(UL), .NCH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync(sync),
    .wait1_code(wait1_code), .wait2_code(wait2_code),
    .pcount(pcount), .period(period), .chan_en(chan_en), .csum_ok(csum_ok),
    .wait1_flag(wait1_flag), .wait2_flag(wait2_flag), .gate(gate), .step(step)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic drive(input vec_t d);
    wait1_code = d.n;
    wait2_code = d.m;
    pcount     = {d.c1, d.c0};
    period     = {d.p1, d.p0};
    chan_en    = d.en;
    csum_ok    = d.ok;
  endtask

  // d is driven, r holds the parameters the frame must actually use
  task automatic run_frame(input vec_t d, input vec_t r);
    int c1 = 0, c2 = 0, win, span0, span1;
    int cg[2], cs[2], fs[2], ec[2], ep[2];
    int wlen;
    bit v[2];
    ec[0] = 4 * int'(r.c0); ep[0] = int'(r.p0);
    ec[1] = 4 * int'(r.c1); ep[1] = int'(r.p1);
    v[0] = (r.c0 != 0) && (r.p0 != 0) && r.ok[0];
    v[1] = (r.c1 != 0) && (r.p1 != 0) && r.ok[1];
    wlen = (int'(r.n) + int'(r.m)) * U;
    span0 = ec[0] * ep[0];
    span1 = ec[1] * ep[1];
    win = wlen + ((span0 > span1) ? span0 : span1) + 8;
    for (int i = 0; i < 2; i++) begin cg[i] = 0; cs[i] = 0; fs[i] = 0; end
    @(negedge clk);
    drive(d);
    sync = 1'b1;
    for (int j = 1; j <= win; j++) begin
      @(negedge clk);
      sync = 1'b0;
      if (wait1_flag) c1++;
      if (wait2_flag) c2++;
      for (int i = 0; i < 2; i++) begin
        if (gate[i]) cg[i]++;
        if (step[i]) begin
          cs[i]++;
          if (fs[i] == 0) fs[i] = j;
        end
      end
    end
    check("R2 first wait length", c1, int'(r.n) * U);
    check("R3 combined wait length", c2, wlen);
    for (int i = 0; i < 2; i++) begin
      check("R5/R7/R9 pulse count", cs[i], (v[i] && d.en[i]) ? ec[i] : 0);
      check("R6/R7 gate length", cg[i], v[i] ? ec[i] * ep[i] + 1 : 0);
      check("R5 first pulse position", fs[i], (v[i] && d.en[i]) ? wlen + ep[i] + 1 : 0);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t d;
    vec_t r;
    int gsum;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {30'd0, gate} | {31'd0, wait1_flag} | {31'd0, wait2_flag} | {30'd0, step}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after release", {wait1_flag, wait2_flag, gate, step}, 0);

    // table of frames: timing, inhibit, enable masking
    for (int k = 0; k < 5; k++) run_frame(TBL[k], TBL[k]);

    // R4: zero wait code keeps last valid codes and channel parameters
    d = '{8'd0, 8'd5, 8'd3, 16'd2, 8'd2, 16'd3, 2'b11, 2'b11};
    r = TBL[4];
    r.en = d.en;
    run_frame(d, r);

    // R5: maximum count, back-to-back pulses
    d = '{8'd1, 8'd1, 8'd255, 16'd1, 8'd0, 16'd1, 2'b11, 2'b11};
    run_frame(d, d);

    // R8: new sync in mid-burst aborts it
    d = '{8'd1, 8'd1, 8'd4, 16'd10, 8'd0, 16'd1, 2'b11, 2'b11};
    @(negedge clk);
    drive(d);
    sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
    repeat (2 * U + 24) @(negedge clk);
    check("R6 gate open mid-burst", int'(gate[0]), 1);
    sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
    check("R8 gate cleared by sync", int'(gate[0]), 0);
    check("R8 waits restarted", int'(wait1_flag), 1);
    repeat (2 * U + 200) @(negedge clk);

    // R8: sync period shorter than the combined wait starves the burst
    d = '{8'd4, 8'd4, 8'd1, 16'd2, 8'd1, 16'd2, 2'b11, 2'b11};
    drive(d);
    gsum = 0;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      sync = 1'b1;
      for (int j = 0; j < ((s == 2) ? 120 : 100); j++) begin
        @(negedge clk);
        sync = 1'b0;
        gsum += int'(gate[0]) + int'(gate[1]) + int'(step[0]) + int'(step[1]);
      end
    end
    check("R8 no burst with short sync period", gsum, 0);
    repeat (100) @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule